// File: doc/BRIEF.md
# Half-Precision Reciprocal Estimate Unit

This unit returns a reciprocal approximation accurate to about eight bits. It handles two kinds of operand. In the first, the operand is a 16-bit floating-point value with a 5-bit exponent and a 10-bit fraction. In the second, it is a 32-bit unsigned fixed-point number whose binary point lies above bit 31. The approximation does not divide the operand. A 9-bit seed is taken from the operand's leading significand bits, and one integer expression (described in R2) maps that seed to a 9-bit estimate. For floating-point operands, the unit then forms the result exponent by negating the input exponent around a fixed offset. It also repacks the result when that result falls in the subnormal range.

Every floating-point special case is settled by fixed rules, and each rule raises a fixed set of exception flags. The special cases are NaN, infinity, zero, operands too small to invert, flush-to-zero underflow and squashed subnormal inputs. An operand is offered with a valid/ready pair, together with its mode, flush-to-zero, default-NaN and rounding controls. The result and its flags come out of a register one cycle after the operand is accepted.

Top module: `recip_est_unit`

## Requirements
- R1: In the clock cycle after an operand is accepted (`in_valid` and `in_ready` both high at a rising edge), `out_valid` is high and `out_result`/`out_flags` hold that operand's answer. In any other cycle `out_valid` is low. `in_ready` is low while `rst` is high and high from the first edge after reset is released.
- R2: The core estimate of a 9-bit seed s (256..511) is ((floor(2^19 / (2s+1)) + 1) >> 1), which always lies in 256..511.
- R3: In half mode (`in_mode`=0), only `in_operand[15:0]` is used and `out_result[31:16]` is zero. For a normal operand with exponent e and fraction f, the result keeps the sign, has exponent 29-e, and has fraction {est[7:0],2'b00}. The estimate est is the core applied to {1,f[9:2]}.
- R4: A subnormal half operand (exponent 0) that is not handled by another rule is pre-scaled as follows. If f[9]=0, the working exponent is -1 and the seed comes from f<<2. If f[9]=1, the working exponent is 0 and the seed comes from f<<1.
- R5: The result exponent is 29 minus the working exponent. When it is 0, the result fraction is {1,est[7:0],0} with exponent field 0. When it is -1, the fraction is {01,est[7:0]} with exponent field 0.
- R6: A NaN operand is returned with fraction bit 9 set. If it was signaling (fraction bit 9 clear), invalid is raised. With `in_dnan`=1, every NaN result is 0x7E00.
- R7: Infinity returns zero of the same sign with no flag. Zero returns infinity of the same sign and raises divide-by-zero.
- R8: A non-zero operand whose magnitude bits [14:0] are below 0x0100 raises overflow and inexact. It returns signed infinity when rounding goes to infinity, otherwise signed 0x7BFF. With `in_rmode` encoded 00 nearest, 01 toward +inf, 10 toward -inf and 11 toward zero, the result goes to infinity for 00, for 01 when the operand is positive, and for 10 when it is negative.
- R9: With `in_ftz`=1, a finite normal operand with exponent 29 or 30 raises underflow and returns zero of the same sign.
- R10: With `in_ftz`=1, a subnormal operand is treated as zero of its sign: divide-by-zero is raised, signed infinity is returned, and input-denormal is raised as well.
- R11: In unsigned mode (`in_mode`=1), an operand with bit 31 clear returns 0xFFFFFFFF. Otherwise bits [31:23] are the seed, and the result is the 9-bit estimate in bits [31:23] with zeros below. The controls have no effect and no flag is raised.
- R12: `out_flags` bit order is [5] invalid, [4] divide-by-zero, [3] overflow, [2] underflow, [1] inexact, [0] input-denormal. At most one of bits [5:2] is set in any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit accepts an operand |
| in_mode | input | 1 | 0 half-precision, 1 unsigned 32-bit |
| in_operand | input | 32 | Operand (half mode uses [15:0]) |
| in_ftz | input | 1 | Flush-to-zero control |
| in_dnan | input | 1 | Default-NaN control |
| in_rmode | input | 2 | Rounding mode (R8 encoding) |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Estimate |
| out_flags | output | 6 | Exception flags (R12 order) |

## Verification
The main path is tried with normal operands whose seeds sit at 256, 384 and the top of the range. Comparing their results separates a correct core from one that is off by one in the divide or the rounding step. Normal operands with both signs and several exponents show whether the exponent is negated around the offset or merely copied. Subnormal operands with the top fraction bit clear and set, and inputs whose result exponent comes out as 0 or -1, tell the two pre-scaling shifts and the two repacking forms apart. Each special class is then run under every rounding mode and under flush-to-zero on and off, which shows that the class decision, not the estimate path, selects both the result and the flags.

// File: rtl/recip_pkg.sv
package recip_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_UP      = 2'd1,
    RM_DOWN    = 2'd2,
    RM_ZERO    = 2'd3
  } rmode_e;

  typedef enum logic [2:0] {
    K_NAN,
    K_INF,
    K_ZERO,
    K_TINY,
    K_FLUSH,
    K_NORMAL
  } kind_e;

  typedef struct packed {
    logic invalid;
    logic divzero;
    logic overflow;
    logic underflow;
    logic inexact;
    logic idenorm;
  } flags_t;

  function automatic logic goes_to_inf(input rmode_e rm, input logic neg);
    case (rm)
      RM_NEAREST: goes_to_inf = 1'b1;
      RM_UP:      goes_to_inf = !neg;
      RM_DOWN:    goes_to_inf = neg;
      default:    goes_to_inf = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/recip_core.sv
module recip_core #(
  parameter int SEED_W = 9
) (
  input  logic [SEED_W-1:0] seed,
  output logic [SEED_W-1:0] est
);
  localparam int NUM_W = 2 * SEED_W + 2;
  localparam logic [NUM_W-1:0] NUMER = NUM_W'(1) << (2 * SEED_W + 1);

  logic [NUM_W-1:0] denom;
  logic [NUM_W-1:0] quot;
  logic [NUM_W-1:0] rounded;
  logic             unused_hi;

  always_comb begin
    denom   = NUM_W'({seed, 1'b1});
    quot    = NUMER / denom;
    rounded = quot + NUM_W'(1);
  end

  assign est       = rounded[SEED_W:1];
  assign unused_hi = ^{rounded[NUM_W-1:SEED_W+1], rounded[0]};
endmodule

// File: rtl/recip_half_front.sv
module recip_half_front
  import recip_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10,
  parameter int SEED_W = 9
) (
  input  logic [EXP_W+FRAC_W:0]    op,
  input  logic                     ftz,
  output kind_e                    kind,
  output logic                     sign,
  output logic                     snan,
  output logic                     squashed,
  output logic signed [EXP_W+1:0]  work_exp,
  output logic [SEED_W-1:0]        seed
);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_OFF = 2 * BIAS - 1;
  localparam logic [FRAC_W-1:0] TINY_LIM = FRAC_W'(1) << (FRAC_W - 2);

  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic [FRAC_W-1:0] f_eff;
  logic [FRAC_W-1:0] nf;
  logic              is_sub;

  always_comb begin
    sign     = op[EXP_W+FRAC_W];
    e        = op[EXP_W+FRAC_W-1:FRAC_W];
    f        = op[FRAC_W-1:0];
    is_sub   = (e == '0) && (f != '0);
    squashed = ftz && is_sub;
    f_eff    = squashed ? '0 : f;
    snan     = !f[FRAC_W-1];

    if (e == '1)
      kind = (f_eff != '0) ? K_NAN : K_INF;
    else if (e == '0 && f_eff == '0)
      kind = K_ZERO;
    else if (e == '0 && f_eff < TINY_LIM)
      kind = K_TINY;
    else if (ftz && 32'(e) >= EXP_OFF)
      kind = K_FLUSH;
    else
      kind = K_NORMAL;

    if (e == '0) begin
      if (!f[FRAC_W-1]) begin
        work_exp = -(EXP_W+2)'(1);
        nf       = f << 2;
      end else begin
        work_exp = '0;
        nf       = f << 1;
      end
    end else begin
      work_exp = (EXP_W+2)'(e);
      nf       = f;
    end
    seed = {1'b1, nf[FRAC_W-1 -: SEED_W-1]};
  end
endmodule

// File: rtl/recip_half_back.sv
module recip_half_back
  import recip_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10,
  parameter int SEED_W = 9
) (
  input  kind_e                    kind,
  input  logic                     sign,
  input  logic                     snan,
  input  logic                     squashed,
  input  logic signed [EXP_W+1:0]  work_exp,
  input  logic [FRAC_W-1:0]        in_frac,
  input  logic [SEED_W-1:0]        est,
  input  logic                     dnan,
  input  rmode_e                   rmode,
  output logic [EXP_W+FRAC_W:0]    res,
  output flags_t                   flags
);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_OFF = 2 * BIAS - 1;
  localparam int WIDE_W  = FRAC_W + SEED_W + 1;
  localparam int HW      = EXP_W + FRAC_W + 1;

  localparam logic [HW-1:0] QNAN_DEF = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [HW-2:0] INF_MAG  = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [HW-2:0] MAX_MAG  = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

  logic signed [EXP_W+1:0] res_exp;
  logic [WIDE_W-1:0]       wide;
  logic [EXP_W-1:0]        exp_field;
  logic [SEED_W-2:0]       est_lo;
  logic                    unused_top;

  assign est_lo     = est[SEED_W-2:0];
  assign unused_top = est[SEED_W-1];

  always_comb begin
    res_exp = (EXP_W+2)'(EXP_OFF) - work_exp;
    if (res_exp == '0) begin
      wide      = {1'b1, est_lo, {(FRAC_W+1){1'b0}}};
      exp_field = '0;
    end else if (res_exp == -(EXP_W+2)'(1)) begin
      wide      = {2'b01, est_lo, {FRAC_W{1'b0}}};
      exp_field = '0;
    end else begin
      wide      = {est_lo, {(FRAC_W+2){1'b0}}};
      exp_field = res_exp[EXP_W-1:0];
    end
  end

  always_comb begin
    flags = '0;
    flags.idenorm = squashed;
    res = {sign, exp_field, wide[WIDE_W-1 -: FRAC_W]};
    case (kind)
      K_NAN: begin
        flags.invalid = snan;
        res = dnan ? QNAN_DEF
                   : {sign, {EXP_W{1'b1}}, 1'b1, in_frac[FRAC_W-2:0]};
      end
      K_INF:  res = {sign, {(HW-1){1'b0}}};
      K_ZERO: begin
        flags.divzero = 1'b1;
        res = {sign, INF_MAG};
      end
      K_TINY: begin
        flags.overflow = 1'b1;
        flags.inexact  = 1'b1;
        res = goes_to_inf(rmode, sign) ? {sign, INF_MAG} : {sign, MAX_MAG};
      end
      K_FLUSH: begin
        flags.underflow = 1'b1;
        res = {sign, {(HW-1){1'b0}}};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/recip_est_unit.sv
module recip_est_unit
  import recip_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10,
  parameter int SEED_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_mode,
  input  logic [INT_W-1:0] in_operand,
  input  logic             in_ftz,
  input  logic             in_dnan,
  input  logic [1:0]       in_rmode,
  output logic             out_valid,
  output logic [INT_W-1:0] out_result,
  output logic [5:0]       out_flags
);
  localparam int HW = EXP_W + FRAC_W + 1;

  kind_e                   kind;
  logic                    h_sign, h_snan, h_squash;
  logic signed [EXP_W+1:0] h_exp;
  logic [SEED_W-1:0]       h_seed, seed, est;
  logic [HW-1:0]           h_res;
  flags_t                  h_flags;
  logic [INT_W-1:0]        nxt_result;
  flags_t                  nxt_flags;
  logic                    accept;
  logic                    ready_q;
  logic                    unused_op;

  assign unused_op = ^in_operand[INT_W-SEED_W-1:0];

  recip_half_front #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SEED_W(SEED_W)) u_front (
    .op       (in_operand[HW-1:0]),
    .ftz      (in_ftz),
    .kind     (kind),
    .sign     (h_sign),
    .snan     (h_snan),
    .squashed (h_squash),
    .work_exp (h_exp),
    .seed     (h_seed)
  );

  assign seed = in_mode ? in_operand[INT_W-1 -: SEED_W] : h_seed;

  recip_core #(.SEED_W(SEED_W)) u_core (
    .seed (seed),
    .est  (est)
  );

  recip_half_back #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SEED_W(SEED_W)) u_back (
    .kind     (kind),
    .sign     (h_sign),
    .snan     (h_snan),
    .squashed (h_squash),
    .work_exp (h_exp),
    .in_frac  (in_operand[FRAC_W-1:0]),
    .est      (est),
    .dnan     (in_dnan),
    .rmode    (rmode_e'(in_rmode)),
    .res      (h_res),
    .flags    (h_flags)
  );

  always_comb begin
    if (in_mode) begin
      nxt_flags  = '0;
      nxt_result = in_operand[INT_W-1] ? {est, {(INT_W-SEED_W){1'b0}}} : '1;
    end else begin
      nxt_flags  = h_flags;
      nxt_result = {{(INT_W-HW){1'b0}}, h_res};
    end
  end

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q    <= 1'b0;
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
    end else begin
      ready_q   <= 1'b1;
      out_valid <= accept;
      if (accept) begin
        out_result <= nxt_result;
        out_flags  <= nxt_flags;
      end
    end
  end
endmodule

// File: rtl/recip_est_unit_chk.sv
module recip_est_unit_chk #(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_mode,
  input logic [INT_W-1:0] in_operand,
  input logic             out_valid,
  input logic [INT_W-1:0] out_result,
  input logic [5:0]       out_flags
);
  localparam int HW = EXP_W + FRAC_W + 1;

  logic acc;
  assign acc = in_valid && in_ready;

  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !out_valid);
  p_ready_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> in_ready);
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && !in_mode) |=> out_result[INT_W-1:HW] == '0);
  p_inf_to_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && !in_mode && in_operand[HW-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})
    |=> (out_result[HW-2:0] == '0 && out_result[HW-1] == $past(in_operand[HW-1])));
  p_zero_divz_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && !in_mode && in_operand[HW-2:0] == '0) |=> out_flags[4]);
  p_allones_r11: assert property (@(posedge clk) disable iff (rst)
    (acc && in_mode && !in_operand[INT_W-1]) |=> (out_result == '1 && out_flags == '0));
  p_u32_shape_r11: assert property (@(posedge clk) disable iff (rst)
    (acc && in_mode && in_operand[INT_W-1])
    |=> (out_result[INT_W-1] && out_result[INT_W-10:0] == '0 && out_flags == '0));
  p_flag_excl_r12: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0(out_flags[5:2]));
endmodule

bind recip_est_unit recip_est_unit_chk #(.INT_W(INT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_mode    (in_mode),
  .in_operand (in_operand),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_flags  (out_flags)
);

// File: tb/recip_est_unit_bench.sv
module recip_est_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_mode = 1'b0;
  logic [31:0] in_operand = '0;
  logic        in_ftz = 1'b0;
  logic        in_dnan = 1'b0;
  logic [1:0]  in_rmode = 2'd0;
  logic        out_valid;
  logic [31:0] out_result;
  logic [5:0]  out_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  recip_est_unit u_recip_est_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_operand(in_operand), .in_ftz(in_ftz),
    .in_dnan(in_dnan), .in_rmode(in_rmode), .out_valid(out_valid),
    .out_result(out_result), .out_flags(out_flags)
  );

  // {req[3:0], mode, ftz, dnan, rmode[1:0], operand[31:0], result[31:0], flags[5:0]}
  localparam int NV = 44;
  localparam logic [78:0] VEC [NV] = '{
    // R3 normal operands, both signs, several exponents, upper bits ignored
    {4'd3, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00003C00, 32'h00003BFC, 6'h00},
    {4'd3, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00003E00, 32'h00003954, 6'h00},
    {4'd3, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0000BC00, 32'h0000BBFC, 6'h00},
    {4'd3, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00004000, 32'h000037FC, 6'h00},
    {4'd3, 1'b0, 1'b0, 1'b0, 2'd0, 32'hFFFF3C00, 32'h00003BFC, 6'h00},
    // R2 core at seeds 384 and 511
    {4'd2, 1'b1, 1'b0, 1'b0, 2'd0, 32'hC0000000, 32'hAA800000, 6'h00},
    {4'd2, 1'b1, 1'b0, 1'b0, 2'd0, 32'hFFFFFFFF, 32'h80000000, 6'h00},
    // R5 result exponent 0 and -1
    {4'd5, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00007400, 32'h000003FE, 6'h00},
    {4'd5, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00007800, 32'h000001FF, 6'h00},
    {4'd5, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0000F800, 32'h000081FF, 6'h00},
    // R4 subnormal pre-scaling
    {4'd4, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00000200, 32'h000077FC, 6'h00},
    {4'd4, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00000100, 32'h00007BFC, 6'h00},
    {4'd4, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00000300, 32'h00007554, 6'h00},
    // R6 NaN handling
    {4'd6, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00007E01, 32'h00007E01, 6'h00},
    {4'd6, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00007C01, 32'h00007E01, 6'h20},
    {4'd6, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0000FC01, 32'h0000FE01, 6'h20},
    {4'd6, 1'b0, 1'b0, 1'b1, 2'd0, 32'h0000FE05, 32'h00007E00, 6'h00},
    {4'd6, 1'b0, 1'b0, 1'b1, 2'd0, 32'h00007D00, 32'h00007E00, 6'h20},
    // R7 infinity and zero
    {4'd7, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00007C00, 32'h00000000, 6'h00},
    {4'd7, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0000FC00, 32'h00008000, 6'h00},
    {4'd7, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00000000, 32'h00007C00, 6'h10},
    {4'd7, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00008000, 32'h0000FC00, 6'h10},
    // R8 tiny operands under each rounding mode
    {4'd8, 1'b0, 1'b0, 1'b0, 2'd0, 32'h000000FF, 32'h00007C00, 6'h0A},
    {4'd8, 1'b0, 1'b0, 1'b0, 2'd3, 32'h000000FF, 32'h00007BFF, 6'h0A},
    {4'd8, 1'b0, 1'b0, 1'b0, 2'd1, 32'h000080FF, 32'h0000FBFF, 6'h0A},
    {4'd8, 1'b0, 1'b0, 1'b0, 2'd2, 32'h000080FF, 32'h0000FC00, 6'h0A},
    {4'd8, 1'b0, 1'b0, 1'b0, 2'd1, 32'h00000001, 32'h00007C00, 6'h0A},
    {4'd8, 1'b0, 1'b0, 1'b0, 2'd2, 32'h00000001, 32'h00007BFF, 6'h0A},
    {4'd8, 1'b0, 1'b0, 1'b0, 2'd3, 32'h00008001, 32'h0000FBFF, 6'h0A},
    // R9 flush-to-zero underflow and its boundary
    {4'd9, 1'b0, 1'b1, 1'b0, 2'd0, 32'h00007400, 32'h00000000, 6'h04},
    {4'd9, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0000F800, 32'h00008000, 6'h04},
    {4'd9, 1'b0, 1'b1, 1'b0, 2'd0, 32'h00007000, 32'h000007FC, 6'h00},
    {4'd9, 1'b0, 1'b1, 1'b0, 2'd0, 32'h00003C00, 32'h00003BFC, 6'h00},
    // R10 subnormal squashing
    {4'd10, 1'b0, 1'b1, 1'b0, 2'd0, 32'h00000001, 32'h00007C00, 6'h11},
    {4'd10, 1'b0, 1'b1, 1'b0, 2'd0, 32'h00008200, 32'h0000FC00, 6'h11},
    {4'd10, 1'b0, 1'b1, 1'b0, 2'd3, 32'h000000FF, 32'h00007C00, 6'h11},
    // R11 unsigned mode
    {4'd11, 1'b1, 1'b0, 1'b0, 2'd0, 32'h7FFFFFFF, 32'hFFFFFFFF, 6'h00},
    {4'd11, 1'b1, 1'b0, 1'b0, 2'd0, 32'h00000000, 32'hFFFFFFFF, 6'h00},
    {4'd11, 1'b1, 1'b0, 1'b0, 2'd0, 32'h40000000, 32'hFFFFFFFF, 6'h00},
    {4'd11, 1'b1, 1'b0, 1'b0, 2'd0, 32'h80000000, 32'hFF800000, 6'h00},
    {4'd11, 1'b1, 1'b1, 1'b1, 2'd3, 32'h80000000, 32'hFF800000, 6'h00},
    {4'd11, 1'b1, 1'b1, 1'b1, 2'd0, 32'h807FFFFF, 32'hFF800000, 6'h00},
    // R12 flag positions under mixed controls
    {4'd12, 1'b0, 1'b1, 1'b1, 2'd1, 32'h00007C01, 32'h00007E00, 6'h20},
    {4'd12, 1'b0, 1'b0, 1'b1, 2'd2, 32'h00008001, 32'h0000FC00, 6'h0A}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset out_valid", {31'b0, out_valid}, 32'd0);
    chk("R1 reset in_ready", {31'b0, in_ready}, 32'd0);
    chk("R1 reset out_result", out_result, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", {31'b0, in_ready}, 32'd1);
    chk("R1 idle out_valid", {31'b0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [78:0] v;
      v = VEC[i];
      in_mode    = v[74];
      in_ftz     = v[73];
      in_dnan    = v[72];
      in_rmode   = v[71:70];
      in_operand = v[69:38];
      in_valid   = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      checks++;
      if (out_valid !== 1'b1 || out_result !== v[37:6] || out_flags !== v[5:0]) begin
        errors++;
        $display("FAIL R%0d vector %0d: actual v=%b %h/%h expected v=1 %h/%h",
                 v[78:75], i, out_valid, out_result, out_flags, v[37:6], v[5:0]);
      end
      @(negedge clk);
      chk("R1 valid drops when idle", {31'b0, out_valid}, 32'd0);
    end

    // R1 back-to-back operands keep order, one per cycle
    in_mode = 1'b0; in_ftz = 1'b0; in_dnan = 1'b0; in_rmode = 2'd0;
    in_operand = 32'h00003C00; in_valid = 1'b1;
    @(negedge clk);
    chk("R1 stream first", out_result, 32'h00003BFC);
    in_operand = 32'h00004000;
    @(negedge clk);
    chk("R1 stream second", out_result, 32'h000037FC);
    chk("R1 stream valid held", {31'b0, out_valid}, 32'd1);
    in_valid = 1'b0;
    in_operand = 32'h00000000;
    @(negedge clk);
    chk("R1 stream end valid", {31'b0, out_valid}, 32'd0);
    chk("R1 held result", out_result, 32'h000037FC);

    // R1 reset mid-run clears the output
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset again ready", {31'b0, in_ready}, 32'd0);
    chk("R1 reset again result", out_result, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready again", {31'b0, in_ready}, 32'd1);

    done = 1'b1;
    finish_run();
  end
endmodule